// File: doc/BRIEF.md
# INT8 Tile Dot-Product Accumulator

This block computes Z += X·Y over three tiles held in an external tile store, with every operand accessed a row at a time. Each 32-bit group of a source row packs four 8-bit values. X holds M rows of K groups. Y holds K rows in a regrouped layout: byte i of group n in row k is inner element 4k+i of output column n. Z holds M rows of N 32-bit accumulators. For every output element the block multiplies the four byte pairs of a group, sums them, repeats over all K groups, and adds the total to the value already in Z. The arithmetic wraps modulo 2^32.

A client sets the signedness mode and the tile sizes, then pulses `start`. For each destination row the block reads the old Z row, then steps through the K rows of Y while holding the X row, with all N columns worked in parallel. Only after that does it write the finished row back. It signals the end with a one-cycle `done`. If the sizes are inconsistent, it raises `err` and touches nothing. Because it accumulates, two operations run back to back over the two halves of a split inner dimension give the full product.

Top module: `i8_tile_dpa`

## Requirements
- R1: After an accepted operation, each Z[m][n] with m < rows and n < ncols equals its old value plus the sum over k < krows and i in 0..3 of X[m][4k+i]·Y[k][4n+i]. Byte j of a row sits at bits [8j+7:8j], and 32-bit element n at bits [32n+31:32n].
- R2: `mode[1]` set makes the X bytes signed (two's complement) and clear makes them unsigned. `mode[0]` does the same for the Y bytes. This gives 00 = both unsigned, 10 = X signed and Y unsigned, 01 = X unsigned and Y signed, 11 = both signed.
- R3: Two operations run in sequence accumulate, so the result equals their summed partial products.
- R4: Elements with n ≥ ncols in written rows keep their old value, and rows with index ≥ rows are never written.
- R5: An operation is rejected when any of the following holds:
  - `cfg_xbytes` ≠ 4·`cfg_krows`
  - any size is zero
  - any size exceeds its maximum

  A rejected operation sets `err`, pulses `done` one cycle after `start`, and writes nothing. The next accepted start clears `err`.
- R6: `busy` is high from the cycle after an accepted start until the operation ends. `done` is a one-cycle pulse, and it coincides with `busy` falling.
- R7: Each destination row is written exactly once per operation, in ascending order, in a single cycle and only while busy. A `start` while busy is ignored.
- R8: After reset, `busy`, `done`, `err` and `z_we` are low.
- R9: Accumulation wraps modulo 2^32 without saturation. For example, 0xFFFFFFFF + 64 gives 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 2 | Signedness: bit 1 X signed, bit 0 Y signed |
| cfg_rows | input | 5 | Destination/X row count M |
| cfg_xbytes | input | 7 | X bytes per row |
| cfg_krows | input | 5 | Y row count K (inner groups) |
| cfg_ncols | input | 5 | Destination element count N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had an invalid configuration |
| x_raddr | output | 4 | X row read address |
| x_rdata | input | 512 | X row read data (combinational) |
| y_raddr | output | 4 | Y row read address |
| y_rdata | input | 512 | Y row read data (combinational) |
| z_raddr | output | 4 | Z row read address |
| z_rdata | input | 512 | Z row read data (combinational) |
| z_we | output | 1 | Z row write enable |
| z_waddr | output | 4 | Z row write address |
| z_wdata | output | 512 | Z row write data |

## Verification
The main function is run with random bytes over all four modes and random sizes. This separates a correct per-operand extension from one that swaps the two mode bits or applies one bit to both sources. Directed full-size tiles of all 0xFF give 64, 4161600 and −16320 for the signed, unsigned and mixed modes. Each of these values betrays a wrong extension at once. A destination preloaded with 0xFFFFFFFF exposes saturation, and two chained half-depth operations expose overwriting instead of accumulating. Partial N and M sizes, a mismatched byte count and a start issued mid-operation show whether untouched lanes and rows stay intact.

// File: rtl/i8dp_pkg.sv
package i8dp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MAC,
        ST_WRITE
    } dp_state_t;

    typedef struct packed {
        logic x_signed;
        logic y_signed;
    } dp_mode_t;

    // Widen a byte to 9 bits, sign or zero filled as selected.
    function automatic logic signed [8:0] widen9(input logic [7:0] b, input logic s);
        return {s & b[7], b};
    endfunction

endpackage

// File: rtl/i8dp_dot4.sv
module i8dp_dot4
    import i8dp_pkg::*;
(
    input  logic [31:0]        xg,
    input  logic [31:0]        yg,
    input  dp_mode_t           mode,
    output logic signed [19:0] sum
);
    logic signed [17:0] prod [4];

    genvar i;
    generate
        for (i = 0; i < 4; i++) begin : g_mul
            assign prod[i] = widen9(xg[8*i +: 8], mode.x_signed)
                           * widen9(yg[8*i +: 8], mode.y_signed);
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int j = 0; j < 4; j++) begin
            sum = sum + {{2{prod[j][17]}}, prod[j]};
        end
    end
endmodule

// File: rtl/i8dp_lane.sv
module i8dp_lane
    import i8dp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        mac_en,
    input  logic [31:0] xg,
    input  logic [31:0] yg,
    input  dp_mode_t    mode,
    output logic [31:0] acc
);
    logic signed [19:0] grp_sum;

    i8dp_dot4 u_dot (
        .xg   (xg),
        .yg   (yg),
        .mode (mode),
        .sum  (grp_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load) begin
            acc <= load_val;
        end else if (mac_en) begin
            acc <= acc + {{12{grp_sum[19]}}, grp_sum};
        end
    end
endmodule

// File: rtl/i8dp_ctrl.sv
module i8dp_ctrl
    import i8dp_pkg::*;
#(
    parameter int MAX_ROWS = 16,
    parameter int MAX_K    = 16,
    parameter int MAX_N    = 16,
    localparam int RW  = $clog2(MAX_ROWS + 1),
    localparam int KW  = $clog2(MAX_K + 1),
    localparam int NW  = $clog2(MAX_N + 1),
    localparam int XBW = $clog2(MAX_K * 4 + 1),
    localparam int RAW = $clog2(MAX_ROWS),
    localparam int KAW = $clog2(MAX_K)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [1:0]     mode,
    input  logic [RW-1:0]  cfg_rows,
    input  logic [XBW-1:0] cfg_xbytes,
    input  logic [KW-1:0]  cfg_krows,
    input  logic [NW-1:0]  cfg_ncols,
    output logic [RAW-1:0] row,
    output logic [KAW-1:0] kidx,
    output logic [NW-1:0]  ncols_q,
    output dp_mode_t       mode_q,
    output logic           load,
    output logic           mac,
    output logic           wr,
    output logic           busy,
    output logic           done,
    output logic           err
);
    dp_state_t     state;
    logic [RW-1:0] rows_q;
    logic [KW-1:0] krows_q;
    logic          cfg_ok;

    always_comb begin
        cfg_ok = (cfg_krows != '0) && (32'(cfg_krows) <= MAX_K)
              && (32'(cfg_xbytes) == 32'(cfg_krows) * 4)
              && (cfg_rows != '0) && (32'(cfg_rows) <= MAX_ROWS)
              && (cfg_ncols != '0) && (32'(cfg_ncols) <= MAX_N);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
            row     <= '0;
            kidx    <= '0;
            rows_q  <= '0;
            krows_q <= '0;
            ncols_q <= '0;
            mode_q  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            rows_q  <= cfg_rows;
                            krows_q <= cfg_krows;
                            ncols_q <= cfg_ncols;
                            mode_q  <= dp_mode_t'(mode);
                            err     <= 1'b0;
                            row     <= '0;
                            state   <= ST_LOAD;
                        end else begin
                            err  <= 1'b1;
                            done <= 1'b1;
                        end
                    end
                end
                ST_LOAD: begin
                    kidx  <= '0;
                    state <= ST_MAC;
                end
                ST_MAC: begin
                    if (32'(kidx) == 32'(krows_q) - 1) begin
                        state <= ST_WRITE;
                    end else begin
                        kidx <= kidx + 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (32'(row) == 32'(rows_q) - 1) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        row   <= row + 1'b1;
                        state <= ST_LOAD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign load = (state == ST_LOAD);
    assign mac  = (state == ST_MAC);
    assign wr   = (state == ST_WRITE);
    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/i8_tile_dpa.sv
module i8_tile_dpa
    import i8dp_pkg::*;
#(
    parameter int MAX_ROWS = 16,
    parameter int MAX_K    = 16,
    parameter int MAX_N    = 16
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic [1:0]                          mode,
    input  logic [$clog2(MAX_ROWS+1)-1:0]       cfg_rows,
    input  logic [$clog2(MAX_K*4+1)-1:0]        cfg_xbytes,
    input  logic [$clog2(MAX_K+1)-1:0]          cfg_krows,
    input  logic [$clog2(MAX_N+1)-1:0]          cfg_ncols,
    output logic                                busy,
    output logic                                done,
    output logic                                err,
    output logic [$clog2(MAX_ROWS)-1:0]         x_raddr,
    input  logic [MAX_K*32-1:0]                 x_rdata,
    output logic [$clog2(MAX_K)-1:0]            y_raddr,
    input  logic [MAX_N*32-1:0]                 y_rdata,
    output logic [$clog2(MAX_ROWS)-1:0]         z_raddr,
    input  logic [MAX_N*32-1:0]                 z_rdata,
    output logic                                z_we,
    output logic [$clog2(MAX_ROWS)-1:0]         z_waddr,
    output logic [MAX_N*32-1:0]                 z_wdata
);
    localparam int NW  = $clog2(MAX_N + 1);
    localparam int RAW = $clog2(MAX_ROWS);
    localparam int KAW = $clog2(MAX_K);

    logic [RAW-1:0] row;
    logic [KAW-1:0] kidx;
    logic [NW-1:0]  ncols_q;
    dp_mode_t       mode_q;
    logic           load, mac, wr;
    logic [31:0]    xg;

    i8dp_ctrl #(
        .MAX_ROWS (MAX_ROWS),
        .MAX_K    (MAX_K),
        .MAX_N    (MAX_N)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .cfg_rows   (cfg_rows),
        .cfg_xbytes (cfg_xbytes),
        .cfg_krows  (cfg_krows),
        .cfg_ncols  (cfg_ncols),
        .row        (row),
        .kidx       (kidx),
        .ncols_q    (ncols_q),
        .mode_q     (mode_q),
        .load       (load),
        .mac        (mac),
        .wr         (wr),
        .busy       (busy),
        .done       (done),
        .err        (err)
    );

    assign xg = x_rdata[32*kidx +: 32];

    genvar n;
    generate
        for (n = 0; n < MAX_N; n++) begin : g_lane
            logic [31:0] acc;
            i8dp_lane u_lane (
                .clk      (clk),
                .rst      (rst),
                .load     (load),
                .load_val (z_rdata[32*n +: 32]),
                .mac_en   (mac && (32'(ncols_q) > n)),
                .xg       (xg),
                .yg       (y_rdata[32*n +: 32]),
                .mode     (mode_q),
                .acc      (acc)
            );
            assign z_wdata[32*n +: 32] = acc;
        end
    endgenerate

    assign x_raddr = row;
    assign y_raddr = kidx;
    assign z_raddr = row;
    assign z_we    = wr;
    assign z_waddr = row;
endmodule

// File: rtl/i8dp_check.sv
module i8dp_check (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic err,
    input logic z_we
);
    // R7: writes happen only inside an operation
    a_r7_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        z_we |-> busy);

    // R7: one row is written in a single cycle
    a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
        z_we |=> !z_we);

    // R6: done lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the end of busy is marked by done
    a_r6_end_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R5: a rejected configuration never writes
    a_r5_err_no_write: assert property (@(posedge clk) disable iff (rst)
        err |-> !z_we);
endmodule

bind i8_tile_dpa i8dp_check u_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .done (done),
    .err  (err),
    .z_we (z_we)
);

// File: tb/i8_tile_dpa_test.sv
`timescale 1ns/1ps
module i8_tile_dpa_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   mode = '0;
    logic [4:0]   cfg_rows = '0;
    logic [6:0]   cfg_xbytes = '0;
    logic [4:0]   cfg_krows = '0;
    logic [4:0]   cfg_ncols = '0;
    logic         busy, done, err;
    logic [3:0]   x_raddr, y_raddr, z_raddr, z_waddr;
    logic [511:0] x_rdata, y_rdata, z_rdata, z_wdata;
    logic         z_we;

    logic [511:0] xm [16];
    logic [511:0] ym [16];
    logic [511:0] zm [16];
    logic [511:0] ze [16];

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int cyc = 0;
    int lastw = -1;
    bit order_bad = 0;

    always #2 clk = ~clk;

    i8_tile_dpa uut (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .cfg_rows(cfg_rows), .cfg_xbytes(cfg_xbytes),
        .cfg_krows(cfg_krows), .cfg_ncols(cfg_ncols),
        .busy(busy), .done(done), .err(err),
        .x_raddr(x_raddr), .x_rdata(x_rdata),
        .y_raddr(y_raddr), .y_rdata(y_rdata),
        .z_raddr(z_raddr), .z_rdata(z_rdata),
        .z_we(z_we), .z_waddr(z_waddr), .z_wdata(z_wdata)
    );

    assign x_rdata = xm[x_raddr];
    assign y_rdata = ym[y_raddr];
    assign z_rdata = zm[z_raddr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (z_we) begin
            zm[z_waddr] <= z_wdata;
            wcount <= wcount + 1;
            if (int'(z_waddr) <= lastw) order_bad <= 1;
            lastw <= int'(z_waddr);
        end
    end

    always @(negedge clk) begin
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input logic [7:0] b, input bit s);
        return s ? 32'($signed(b)) : {24'd0, b};
    endfunction

    task automatic model(input logic [1:0] md, input int r, input int kr, input int nc);
        for (int m = 0; m < r; m++) begin
            for (int n = 0; n < nc; n++) begin
                logic [31:0] a;
                a = ze[m][32*n +: 32];
                for (int k = 0; k < kr; k++) begin
                    for (int i = 0; i < 4; i++) begin
                        a = a + ext(xm[m][8*(4*k+i) +: 8], md[1]) * ext(ym[k][8*(4*n+i) +: 8], md[0]);
                    end
                end
                ze[m][32*n +: 32] = a;
            end
        end
    endtask

    function automatic logic [511:0] rnd_row();
        logic [511:0] v;
        for (int j = 0; j < 16; j++) v[32*j +: 32] = $urandom;
        return v;
    endfunction

    // Launch one operation and wait for done; optional mid-run stray start.
    task automatic run_op(input logic [1:0] md, input int r, input int xb, input int kr,
                          input int nc, input bit stray);
        int cnt;
        wcount = 0;
        lastw = -1;
        order_bad = 0;
        @(negedge clk);
        mode = md; cfg_rows = 5'(r); cfg_xbytes = 7'(xb);
        cfg_krows = 5'(kr); cfg_ncols = 5'(nc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 5000) begin
            if (stray && cnt == 3) begin
                start = 1'b1; cfg_xbytes = 7'd3; mode = ~md; cfg_ncols = 5'd1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        if (cnt >= 5000) begin
            errors++;
            $display("FAIL watchdog waiting for done");
        end
    endtask

    task automatic cmp_z(input string req);
        bit ok = 1;
        int bad = 0;
        for (int m = 0; m < 16; m++) if (zm[m] !== ze[m]) begin ok = 0; bad = m; end
        chk(ok, req, zm[bad][31:0], ze[bad][31:0]);
    endtask

    task automatic fill_all(input logic [7:0] xv, input logic [7:0] yv, input logic [31:0] zv);
        for (int m = 0; m < 16; m++) begin
            xm[m] = {64{xv}}; ym[m] = {64{yv}}; zm[m] = {16{zv}}; ze[m] = zm[m];
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        fill_all(8'h00, 8'h00, 32'h0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(!busy && !done && !err && !z_we, "R8 reset outputs", {busy, done, err, z_we}, 0);

        // R2: full-size all 0xFF, four modes
        fill_all(8'hFF, 8'hFF, 32'h0);
        run_op(2'b11, 16, 64, 16, 16, 0);
        chk(zm[0][31:0] == 32'd64, "R2 both signed", zm[0][31:0], 32'd64);
        fill_all(8'hFF, 8'hFF, 32'h0);
        run_op(2'b00, 16, 64, 16, 16, 0);
        chk(zm[15][511:480] == 32'd4161600, "R2 both unsigned", zm[15][511:480], 32'd4161600);
        fill_all(8'hFF, 8'hFF, 32'h0);
        run_op(2'b10, 16, 64, 16, 16, 0);
        chk(zm[3][63:32] == 32'hFFFFC040, "R2 X signed Y unsigned", zm[3][63:32], 32'hFFFFC040);
        fill_all(8'hFF, 8'h01, 32'h0);
        run_op(2'b01, 16, 64, 16, 16, 0);
        chk(zm[2][31:0] == 32'd16320, "R2 X unsigned Y signed", zm[2][31:0], 32'd16320);
        chk(wcount == 16 && !order_bad, "R7 one write per row ascending", wcount, 16);

        // R9 wrap
        fill_all(8'hFF, 8'hFF, 32'hFFFFFFFF);
        run_op(2'b11, 1, 64, 16, 1, 0);
        chk(zm[0][31:0] == 32'd63, "R9 wrap modulo 2^32", zm[0][31:0], 32'd63);
        // R4 untouched lane and row
        chk(zm[0][63:32] == 32'hFFFFFFFF && zm[1] == {16{32'hFFFFFFFF}},
            "R4 lanes/rows beyond size", zm[0][63:32], 32'hFFFFFFFF);

        // R1 / R4 random operations across modes and sizes
        for (int t = 0; t < 24; t++) begin
            int r, kr, nc;
            logic [1:0] md;
            r = 1 + int'($urandom % 16); kr = 1 + int'($urandom % 16);
            nc = 1 + int'($urandom % 16); md = 2'($urandom);
            for (int m = 0; m < 16; m++) begin
                xm[m] = rnd_row(); ym[m] = rnd_row(); zm[m] = rnd_row(); ze[m] = zm[m];
            end
            model(md, r, kr, nc);
            run_op(md, r, 4 * kr, kr, nc, 0);
            cmp_z("R1 random dot-product accumulate R4");
            chk(wcount == r, "R7 write count", wcount, r);
        end

        // R3 chained split inner dimension
        for (int m = 0; m < 16; m++) begin
            xm[m] = rnd_row(); ym[m] = rnd_row(); zm[m] = '0; ze[m] = '0;
        end
        model(2'b11, 16, 8, 16);
        run_op(2'b11, 16, 32, 8, 16, 0);
        for (int m = 0; m < 16; m++) begin xm[m] = rnd_row(); ym[m] = rnd_row(); end
        model(2'b11, 16, 8, 16);
        run_op(2'b11, 16, 32, 8, 16, 0);
        cmp_z("R3 chained accumulation");

        // R5 mismatch rejected
        for (int m = 0; m < 16; m++) begin zm[m] = rnd_row(); ze[m] = zm[m]; end
        run_op(2'b00, 4, 20, 4, 4, 0);
        chk(err == 1'b1, "R5 mismatch sets err", err, 1);
        chk(wcount == 0, "R5 no write on error", wcount, 0);
        cmp_z("R5 Z unchanged after error");
        run_op(2'b00, 4, 64, 0, 4, 0);
        chk(err == 1'b1 && wcount == 0, "R5 zero K rejected", wcount, 0);

        // R6 / R5 valid start clears err, busy drops with done
        model(2'b01, 2, 2, 3);
        run_op(2'b01, 2, 8, 2, 3, 0);
        chk(err == 1'b0, "R5 err cleared by accepted start", err, 0);
        chk(!busy, "R6 busy low at done", busy, 0);
        @(negedge clk);
        chk(!done, "R6 done one cycle", done, 0);
        cmp_z("R1 after error recovery");

        // R7 start while busy ignored
        for (int m = 0; m < 16; m++) begin
            xm[m] = rnd_row(); ym[m] = rnd_row(); zm[m] = rnd_row(); ze[m] = zm[m];
        end
        model(2'b10, 5, 6, 9);
        run_op(2'b10, 5, 24, 6, 9, 1);
        chk(err == 1'b0 && wcount == 5, "R7 stray start ignored", wcount, 5);
        cmp_z("R7 result unaffected by stray start");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule